// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a 32-bit memory address for a two-operand machine with eight 32-bit general registers. A request supplies an addressing mode, a base register number, an index register number, a 2-bit scale and a displacement that is either narrow (8 bits, sign-extended) or wide (32 bits). The base and index values come from an internal eight-entry register file, which has its own write port for loading.

Four modes are supported: register indirect, base plus displacement, base plus scaled index, and base plus scaled index plus displacement. The two non-indexed modes refuse the stack pointer (register 4) and the frame pointer (register 5) as the base. The two indexed modes accept any base but refuse the stack pointer as the index. A refused combination raises an illegal flag and forces the address to zero.

The result passes through one register stage. The request strobe has no ready partner and the block applies no back-pressure: it accepts one request on every clock in which the strobe is high. Each accepted request produces a one-cycle valid pulse on the next clock. Address and illegal flag hold their values until the next request.

Top module: `ea_addr_gen`

## Requirements
- R1: A register-file write (wr_en high) takes effect at the clock edge. A request in the same cycle that reads the register being written uses the old value.
- R2: Mode 0 (indirect) gives address = base value. Base number 4 or 5 is illegal in this mode.
- R3: Mode 1 (base plus displacement) gives address = base + displacement, and base number 4 or 5 is illegal. With disp_wide = 0 the displacement is disp[7:0] sign-extended and disp[31:8] is ignored. With disp_wide = 1 all 32 bits are used.
- R4: Mode 2 (scaled index) gives address = base + (index << scale) for scale 0 to 3, with any base register allowed. The displacement is ignored.
- R5: Mode 3 (scaled index plus displacement) gives address = base + (index << scale) + displacement, with the displacement extended as in R3 and any base register allowed.
- R6: In modes 2 and 3, index number 4 is illegal. Every other index number is allowed.
- R7: For an illegal request, ea_illegal is 1 and ea_addr is 0. For a legal request, ea_illegal is 0.
- R8: All additions and shifts wrap modulo 2^32, and no overflow is reported.
- R9: ea_valid is high in exactly the cycle after each cycle with req high, and is low otherwise. ea_addr and ea_illegal keep their values while no request arrives.
- R10: A synchronous active-high rst clears ea_valid, ea_illegal and ea_addr on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register-file write enable |
| wr_sel | input | 3 | Register number to write |
| wr_data | input | 32 | Value to write |
| req | input | 1 | Request strobe, one request per high cycle |
| mode | input | 2 | 0 indirect, 1 base+disp, 2 base+scaled index, 3 base+scaled index+disp |
| base_sel | input | 3 | Base register number |
| index_sel | input | 3 | Index register number |
| scale | input | 2 | Index shift amount, 0 to 3 |
| disp_wide | input | 1 | 1: 32-bit displacement, 0: sign-extended disp[7:0] |
| disp | input | 32 | Displacement |
| ea_valid | output | 1 | One-cycle result strobe |
| ea_addr | output | 32 | Effective address, 0 when illegal |
| ea_illegal | output | 1 | Illegal register choice for the last request |

## Verification
The hardest case to reach from the ports is a request that reads a register in the same cycle that register is being rewritten. The stimulus writes a new value and issues a request naming that register in a single cycle, expects the old value, and then repeats the request to see the new value. The main sweep covers every mode, base, index, scale and displacement width. It uses register contents with high bits set and displacements with bit 7 set, so that wrap-around, sign extension and the ignored upper displacement bits all show at the address output.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [1:0] {
    EA_IND   = 2'd0,
    EA_BDISP = 2'd1,
    EA_BIDX  = 2'd2,
    EA_BIDXD = 2'd3
  } ea_mode_e;

  typedef struct packed {
    logic use_idx;
    logic use_disp;
    logic base_limited;
    logic idx_limited;
  } ea_ctl_t;

  function automatic ea_ctl_t ea_decode(ea_mode_e m);
    ea_ctl_t c;
    c = '0;
    case (m)
      EA_IND:   begin c.base_limited = 1'b1; end
      EA_BDISP: begin c.base_limited = 1'b1; c.use_disp = 1'b1; end
      EA_BIDX:  begin c.use_idx = 1'b1; c.idx_limited = 1'b1; end
      default:  begin c.use_idx = 1'b1; c.use_disp = 1'b1; c.idx_limited = 1'b1; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
  parameter int DW  = 32,
  parameter int NREG = 8,
  parameter int NRD = 2,
  localparam int AW = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           wsel,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  rsel,
  output logic [NRD-1:0][DW-1:0]  rdata
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we) regs[wsel] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = regs[rsel[p]];
  end

endmodule

// File: rtl/ea_legality.sv
module ea_legality
  import ea_pkg::*;
#(
  parameter int AW     = 3,
  parameter int SP_NUM = 4,
  parameter int FP_NUM = 5
) (
  input  ea_ctl_t       ctl,
  input  logic [AW-1:0] base_sel,
  input  logic [AW-1:0] index_sel,
  output logic          illegal
);

  logic base_is_frame;
  logic idx_is_stack;

  always_comb begin
    base_is_frame = (base_sel == AW'(SP_NUM)) || (base_sel == AW'(FP_NUM));
    idx_is_stack  = (index_sel == AW'(SP_NUM));
    illegal = (ctl.base_limited && base_is_frame) ||
              (ctl.idx_limited && idx_is_stack);
  end

endmodule

// File: rtl/ea_adder.sv
module ea_adder
  import ea_pkg::*;
#(
  parameter int DW     = 32,
  parameter int SCW    = 2,
  parameter int NARROW = 8
) (
  input  ea_ctl_t         ctl,
  input  logic [DW-1:0]   base_val,
  input  logic [DW-1:0]   index_val,
  input  logic [SCW-1:0]  scale,
  input  logic            disp_wide,
  input  logic [DW-1:0]   disp,
  output logic [DW-1:0]   sum
);

  logic [DW-1:0] disp_ext;
  logic [DW-1:0] idx_term;
  logic [DW-1:0] disp_term;

  always_comb begin
    if (disp_wide) disp_ext = disp;
    else           disp_ext = {{(DW-NARROW){disp[NARROW-1]}}, disp[NARROW-1:0]};
    idx_term  = ctl.use_idx  ? (index_val << scale) : '0;
    disp_term = ctl.use_disp ? disp_ext : '0;
    sum       = base_val + idx_term + disp_term;
  end

endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NREG   = 8,
  parameter int SCW    = 2,
  parameter int NARROW = 8,
  parameter int SP_NUM = 4,
  parameter int FP_NUM = 5,
  localparam int AW    = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_sel,
  input  logic [DW-1:0]  wr_data,
  input  logic           req,
  input  logic [1:0]     mode,
  input  logic [AW-1:0]  base_sel,
  input  logic [AW-1:0]  index_sel,
  input  logic [SCW-1:0] scale,
  input  logic           disp_wide,
  input  logic [DW-1:0]  disp,
  output logic           ea_valid,
  output logic [DW-1:0]  ea_addr,
  output logic           ea_illegal
);

  ea_ctl_t              ctl;
  logic [1:0][AW-1:0]   rsel;
  logic [1:0][DW-1:0]   rdata;
  logic                 bad;
  logic [DW-1:0]        sum;

  assign ctl     = ea_decode(ea_mode_e'(mode));
  assign rsel[0] = base_sel;
  assign rsel[1] = index_sel;

  ea_regfile #(.DW(DW), .NREG(NREG), .NRD(2)) u_rf (
    .clk   (clk),
    .we    (wr_en),
    .wsel  (wr_sel),
    .wdata (wr_data),
    .rsel  (rsel),
    .rdata (rdata)
  );

  ea_legality #(.AW(AW), .SP_NUM(SP_NUM), .FP_NUM(FP_NUM)) u_chk (
    .ctl       (ctl),
    .base_sel  (base_sel),
    .index_sel (index_sel),
    .illegal   (bad)
  );

  ea_adder #(.DW(DW), .SCW(SCW), .NARROW(NARROW)) u_add (
    .ctl       (ctl),
    .base_val  (rdata[0]),
    .index_val (rdata[1]),
    .scale     (scale),
    .disp_wide (disp_wide),
    .disp      (disp),
    .sum       (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_valid   <= 1'b0;
      ea_illegal <= 1'b0;
      ea_addr    <= '0;
    end else begin
      ea_valid <= req;
      if (req) begin
        ea_illegal <= bad;
        ea_addr    <= bad ? '0 : sum;
      end
    end
  end

  // R9: one pulse per request
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req |=> ea_valid);
  a_r9_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !req |=> !ea_valid);
  // R9: result holds between requests
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !req |=> $stable(ea_addr) && $stable(ea_illegal));
  // R7: illegal forces a zero address
  a_r7_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    ea_illegal |-> ea_addr == '0);
  // R6: stack pointer as index in scaled modes
  a_r6_sp_index: assert property (@(posedge clk) disable iff (rst)
    (req && mode[1] && index_sel == AW'(SP_NUM)) |=> ea_illegal);
  // R2, R3: restricted bases in non-indexed modes
  a_r2_base_limit: assert property (@(posedge clk) disable iff (rst)
    (req && !mode[1] && (base_sel == AW'(SP_NUM) || base_sel == AW'(FP_NUM)))
    |=> ea_illegal);
  // R10: reset clears the output stage
  a_r10_reset: assert property (@(posedge clk)
    rst |=> !ea_valid && !ea_illegal && ea_addr == '0);

endmodule

// File: tb/ea_addr_gen_tb.sv
`timescale 1ns/1ps
module ea_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        req = 1'b0;
  logic [1:0]  mode = '0;
  logic [2:0]  base_sel = '0;
  logic [2:0]  index_sel = '0;
  logic [1:0]  scale = '0;
  logic        disp_wide = 1'b0;
  logic [31:0] disp = '0;
  logic        ea_valid;
  logic [31:0] ea_addr;
  logic        ea_illegal;

  int checks = 0;
  int errors = 0;
  logic [31:0] shadow [8];

  always #2 clk = ~clk;

  ea_addr_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req(req), .mode(mode), .base_sel(base_sel), .index_sel(index_sel),
    .scale(scale), .disp_wide(disp_wide), .disp(disp),
    .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_illegal(ea_illegal)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic void model(input int m, input int b, input int ix,
                                input int sc, input bit w, input logic [31:0] d,
                                output bit ill, output logic [31:0] a);
    logic [31:0] dx;
    dx = w ? d : {{24{d[7]}}, d[7:0]};
    ill = 1'b0;
    a = shadow[b];
    if (m < 2) begin
      if (b == 4 || b == 5) ill = 1'b1;
      if (m == 1) a = a + dx;
    end else begin
      if (ix == 4) ill = 1'b1;
      a = a + shadow[ix] * (32'd1 << sc);
      if (m == 3) a = a + dx;
    end
    if (ill) a = '0;
  endfunction

  task automatic write_reg(input int r, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(r); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    shadow[r] = v;
  endtask

  task automatic request(input int m, input int b, input int ix, input int sc,
                         input bit w, input logic [31:0] d, input string rq);
    bit ill;
    logic [31:0] a;
    model(m, b, ix, sc, w, d, ill, a);
    @(negedge clk);
    req = 1'b1; mode = 2'(m); base_sel = 3'(b); index_sel = 3'(ix);
    scale = 2'(sc); disp_wide = w; disp = d;
    @(negedge clk);
    req = 1'b0;
    chk(ea_valid == 1'b1, "R9 valid", 32'(ea_valid), 32'd1);
    chk(ea_addr == a, rq, ea_addr, a);
    chk(ea_illegal == ill, (ill ? "R7 illegal flag" : "R7 legal flag"),
        32'(ea_illegal), 32'(ill));
    @(negedge clk);
    chk(ea_valid == 1'b0, "R9 pulse", 32'(ea_valid), 32'd0);
    chk(ea_addr == a, "R9 hold", ea_addr, a);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] dv [3];
    string nm [4];
    dv[0] = 32'hABCD_0080;   // narrow: -128, upper bits must be ignored
    dv[1] = 32'h0000_007F;
    dv[2] = 32'hF123_4567;
    nm[0] = "R2 indirect";
    nm[1] = "R3 base+disp";
    nm[2] = "R4 scaled index";
    nm[3] = "R5 scaled index+disp";

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ea_valid == 1'b0 && ea_illegal == 1'b0 && ea_addr == '0,
        "R10 reset state", ea_addr, 32'd0);

    for (int r = 0; r < 8; r++)
      write_reg(r, 32'h9E37_79B9 * 32'(r + 1) + 32'h7000_0000);

    // sweep: wrap-around (R8) shows through large register values
    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 8; b++)
        for (int ix = 0; ix < 8; ix++)
          for (int sc = 0; sc < 4; sc++)
            for (int w = 0; w < 2; w++)
              for (int k = 0; k < 3; k++)
                if (m >= 2 || (ix == 0 && sc == 0))
                  request(m, b, ix, sc, w[0], dv[k], nm[m]);

    // R8: explicit wrap
    write_reg(1, 32'hFFFF_FFF0);
    write_reg(2, 32'h8000_0001);
    request(3, 1, 2, 3, 1'b1, 32'h0000_0020, "R8 wrap");

    // R6: index 4 with a legal base in both scaled modes
    request(2, 0, 4, 1, 1'b0, 32'h0, "R6 sp index");
    request(3, 7, 4, 0, 1'b1, 32'h1234, "R6 sp index disp");

    // R1: same-cycle write and read returns old value
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd3; wr_data = 32'h5555_0000;
    req = 1'b1; mode = 2'd0; base_sel = 3'd3; index_sel = 3'd0;
    scale = 2'd0; disp_wide = 1'b0; disp = '0;
    @(negedge clk);
    wr_en = 1'b0; req = 1'b0;
    chk(ea_addr == shadow[3], "R1 old value on collision", ea_addr, shadow[3]);
    shadow[3] = 32'h5555_0000;
    request(0, 3, 0, 0, 1'b0, 32'h0, "R1 new value after write");

    // R10: reset in the middle of a request
    @(negedge clk);
    req = 1'b1; mode = 2'd1; base_sel = 3'd6; rst = 1'b1;
    @(negedge clk);
    req = 1'b0; rst = 1'b0;
    chk(ea_valid == 1'b0 && ea_addr == '0 && ea_illegal == 1'b0,
        "R10 mid-run reset", ea_addr, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule